// File: doc/BRIEF.md
# Accumulator Machine Fetch-Decode Sequencer

This block is the front end of a small accumulator processor. It keeps the program counter, the address register and the instruction register. It reads each instruction word from a synchronous memory, steps the program counter, and sorts the word into one of three classes: memory-operand, accumulator-operation or input/output. A memory-operand instruction in indirect mode needs one more memory read. That read fetches the real operand address before the instruction is passed on.

The decoded instruction goes to an execute stage through a valid/done handshake. The class, the opcode, the 12-bit operand field and the effective address stay steady until the execute stage signals done. At that moment the execute stage can also redirect the next fetch, which is how branches work. Memory words are 16 bits wide: bit 15 is the mode bit, bits 14..12 are the opcode and bits 11..0 are the operand field.

The sequencer moves through five named states:
- `ST_FETCH_ADDR`: issue a read at PC. Next state is `ST_FETCH_READ`.
- `ST_FETCH_READ`: capture the instruction register and add 1 to PC. Next state is `ST_DECODE`.
- `ST_DECODE`: load AR from the operand field. An indirect memory-operand instruction issues a pointer read and goes to `ST_INDIRECT`. Every other instruction goes to `ST_HANDOFF`.
- `ST_INDIRECT`: load AR from the pointer word. Next state is `ST_HANDOFF`.
- `ST_HANDOFF`: wait for done, then return to `ST_FETCH_ADDR`.

Top module: `fetch_sequencer`

## Requirements
- R1: A synchronous reset clears PC, AR and IR and enters `ST_FETCH_ADDR`. While reset is held, `mem_rd_en` is 1, `mem_addr` is 0 and `exec_valid` is 0.
- R2: Each instruction is read with exactly one memory read at the current PC. PC then advances by one, so instructions run in consecutive order.
- R3: PC advances modulo 4096. After the instruction at 0xFFF, the next fetch is at 0x000.
- R4: `opcode` shows instruction bits 14..12 and `operand` shows bits 11..0.
- R5: An opcode other than 3'b111 gives `ins_class` 2'd0 (memory-operand).
- R6: Opcode 3'b111 gives `ins_class` 2'd1 (accumulator operation) when bit 15 is 0, or 2'd2 (input/output) when bit 15 is 1. Neither class makes any memory read beyond the instruction fetch, and `eff_addr` equals bits 11..0.
- R7: A memory-operand instruction with bit 15 = 0 presents `eff_addr` equal to bits 11..0, with no extra read.
- R8: A memory-operand instruction with bit 15 = 1 makes one extra read at address bits 11..0. It then presents `eff_addr` equal to bits 11..0 of the word returned.
- R9: `exec_valid` first rises 4 cycles after the cycle in which done was accepted, or 5 cycles for an indirect instruction. It drops in the cycle after done.
- R10: While `exec_valid` is 1 and `exec_done` is 0, `exec_valid`, `ins_class`, `opcode`, `operand` and `eff_addr` hold their values.
- R11: When `pc_load` is 1 together with `exec_done` in the handoff state, the next fetch address becomes `pc_load_val`. When `pc_load` is 1 without `exec_done`, it has no effect.
- R12: A read request lasts one cycle. `mem_addr` holds the same value in the following cycle, when `mem_rdata` is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 12 | Memory word address |
| mem_rd_en | output | 1 | Read request; data returns one cycle later |
| mem_rdata | input | 16 | Read data, valid the cycle after `mem_rd_en` |
| exec_valid | output | 1 | Decoded instruction on offer to the execute stage |
| exec_done | input | 1 | Execute stage has finished with the instruction |
| pc_load | input | 1 | Replace the next PC, sampled with `exec_done` |
| pc_load_val | input | 12 | New PC value for a branch |
| ins_class | output | 2 | 0 memory-operand, 1 accumulator op, 2 input/output |
| opcode | output | 3 | Instruction bits 14..12 |
| operand | output | 12 | Instruction bits 11..0 |
| eff_addr | output | 12 | Effective address (AR) |

## Verification
A wrong PC shows up within one instruction, because the word fetched comes from the wrong location and the decoded fields differ from the program the bench placed in memory. A wrong sequencer state or a wrong indirect decision shows at the ports as a handoff that arrives one cycle early or late, or as a read count per instruction that is off by one. A wrong AR shows in `eff_addr` at the very next handoff. A branch taken at the wrong moment, or one that should have been ignored, shows as the wrong instruction at the next handoff.

// File: rtl/fds_pkg.sv
package fds_pkg;

    typedef enum logic [2:0] {
        ST_FETCH_ADDR = 3'd0,
        ST_FETCH_READ = 3'd1,
        ST_DECODE     = 3'd2,
        ST_INDIRECT   = 3'd3,
        ST_HANDOFF    = 3'd4
    } fds_state_t;

    typedef enum logic [1:0] {
        CL_MEM = 2'd0,
        CL_REG = 2'd1,
        CL_IO  = 2'd2
    } fds_class_t;

    typedef enum logic [1:0] {
        AS_PC    = 2'd0,
        AS_FIELD = 2'd1,
        AS_AR    = 2'd2
    } fds_addr_sel_t;

endpackage

// File: rtl/fds_pc.sv
module fds_pc #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    output logic [AW-1:0] pc
);
    localparam logic [AW-1:0] ONE = AW'(1);

    always_ff @(posedge clk) begin
        if (rst)
            pc <= '0;
        else if (load)
            pc <= load_val;
        else if (inc)
            pc <= pc + ONE;   // wraps naturally at the top of the space
    end
endmodule

// File: rtl/fds_classify.sv
module fds_classify
    import fds_pkg::*;
#(
    parameter int DW  = 16,
    parameter int AW  = 12,
    parameter int OPW = 3
) (
    input  logic [DW-1:0]  ir,
    output fds_class_t     cls,
    output logic [OPW-1:0] opc,
    output logic [AW-1:0]  field,
    output logic           needs_ind
);
    localparam int            MODE_BIT = DW - 1;
    localparam int            OPC_LSB  = AW;
    localparam logic [OPW-1:0] OPC_SYS = {OPW{1'b1}};

    logic mode;

    always_comb begin
        mode  = ir[MODE_BIT];
        opc   = ir[OPC_LSB +: OPW];
        field = ir[AW-1:0];
        if (opc != OPC_SYS) begin
            cls       = CL_MEM;
            needs_ind = mode;
        end else begin
            cls       = mode ? CL_IO : CL_REG;
            needs_ind = 1'b0;
        end
    end
endmodule

// File: rtl/fds_ctrl.sv
module fds_ctrl
    import fds_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          needs_ind,
    input  logic          exec_done,
    input  logic          pc_load,
    output fds_state_t    state,
    output logic          rd_en,
    output fds_addr_sel_t addr_sel,
    output logic          ir_load,
    output logic          pc_inc,
    output logic          pc_take,
    output logic          ar_from_field,
    output logic          ar_from_mem,
    output logic          valid
);
    fds_state_t nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_FETCH_ADDR;
        else     state <= nxt;
    end

    always_comb begin
        nxt           = state;
        rd_en         = 1'b0;
        addr_sel      = AS_AR;
        ir_load       = 1'b0;
        pc_inc        = 1'b0;
        pc_take       = 1'b0;
        ar_from_field = 1'b0;
        ar_from_mem   = 1'b0;
        valid         = 1'b0;
        unique case (state)
            ST_FETCH_ADDR: begin
                rd_en    = 1'b1;
                addr_sel = AS_PC;
                nxt      = ST_FETCH_READ;
            end
            ST_FETCH_READ: begin
                addr_sel = AS_PC;
                ir_load  = 1'b1;
                pc_inc   = 1'b1;
                nxt      = ST_DECODE;
            end
            ST_DECODE: begin
                addr_sel      = AS_FIELD;
                ar_from_field = 1'b1;
                rd_en         = needs_ind;
                nxt           = needs_ind ? ST_INDIRECT : ST_HANDOFF;
            end
            ST_INDIRECT: begin
                addr_sel    = AS_FIELD;
                ar_from_mem = 1'b1;
                nxt         = ST_HANDOFF;
            end
            ST_HANDOFF: begin
                valid = 1'b1;
                if (exec_done) begin
                    pc_take = pc_load;
                    nxt     = ST_FETCH_ADDR;
                end
            end
            default: nxt = ST_FETCH_ADDR;
        endcase
    end
endmodule

// File: rtl/fetch_sequencer.sv
module fetch_sequencer
    import fds_pkg::*;
#(
    parameter int AW  = 12,
    parameter int DW  = 16,
    parameter int OPW = 3
) (
    input  logic           clk,
    input  logic           rst,
    output logic [AW-1:0]  mem_addr,
    output logic           mem_rd_en,
    input  logic [DW-1:0]  mem_rdata,
    output logic           exec_valid,
    input  logic           exec_done,
    input  logic           pc_load,
    input  logic [AW-1:0]  pc_load_val,
    output logic [1:0]     ins_class,
    output logic [OPW-1:0] opcode,
    output logic [AW-1:0]  operand,
    output logic [AW-1:0]  eff_addr
);
    fds_state_t    state;
    fds_addr_sel_t addr_sel;
    fds_class_t    cls;
    logic [AW-1:0] pc, ar, field;
    logic [DW-1:0] ir;
    logic          needs_ind, ir_load, pc_inc, pc_take, ar_from_field, ar_from_mem;

    fds_pc #(.AW(AW)) u_pc (
        .clk(clk), .rst(rst), .inc(pc_inc), .load(pc_take),
        .load_val(pc_load_val), .pc(pc)
    );

    fds_classify #(.DW(DW), .AW(AW), .OPW(OPW)) u_cls (
        .ir(ir), .cls(cls), .opc(opcode), .field(field), .needs_ind(needs_ind)
    );

    fds_ctrl u_ctrl (
        .clk(clk), .rst(rst), .needs_ind(needs_ind), .exec_done(exec_done),
        .pc_load(pc_load), .state(state), .rd_en(mem_rd_en), .addr_sel(addr_sel),
        .ir_load(ir_load), .pc_inc(pc_inc), .pc_take(pc_take),
        .ar_from_field(ar_from_field), .ar_from_mem(ar_from_mem), .valid(exec_valid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ir <= '0;
            ar <= '0;
        end else begin
            if (ir_load)       ir <= mem_rdata;
            if (ar_from_field) ar <= field;
            else if (ar_from_mem) ar <= mem_rdata[AW-1:0];
        end
    end

    always_comb begin
        unique case (addr_sel)
            AS_PC:    mem_addr = pc;
            AS_FIELD: mem_addr = field;
            default:  mem_addr = ar;
        endcase
        ins_class = cls;
        operand   = field;
        eff_addr  = ar;
    end
endmodule

// File: rtl/fds_checker.sv
module fds_checker #(
    parameter int AW  = 12,
    parameter int OPW = 3
) (
    input logic           clk,
    input logic           rst,
    input logic [AW-1:0]  mem_addr,
    input logic           mem_rd_en,
    input logic           exec_valid,
    input logic           exec_done,
    input logic [1:0]     ins_class,
    input logic [OPW-1:0] opcode,
    input logic [AW-1:0]  operand,
    input logic [AW-1:0]  eff_addr
);
    AST_RESET_FETCH: assert property (@(posedge clk) rst |=> (mem_rd_en && mem_addr == '0 && !exec_valid)); // R1
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst) mem_rd_en |=> $stable(mem_addr)); // R12
    AST_SINGLE_READ: assert property (@(posedge clk) disable iff (rst) mem_rd_en |=> !mem_rd_en); // R12
    AST_CLASS_MEM: assert property (@(posedge clk) disable iff (rst) (exec_valid && opcode != {OPW{1'b1}}) |-> ins_class == 2'd0); // R5
    AST_CLASS_SYS: assert property (@(posedge clk) disable iff (rst) (exec_valid && opcode == {OPW{1'b1}}) |-> (ins_class != 2'd0 && ins_class != 2'd3 && eff_addr == operand)); // R6
    AST_HOLD_WAIT: assert property (@(posedge clk) disable iff (rst) (exec_valid && !exec_done) |=> (exec_valid && $stable(ins_class) && $stable(opcode) && $stable(operand) && $stable(eff_addr))); // R10
    AST_DROP_AFTER_DONE: assert property (@(posedge clk) disable iff (rst) (exec_valid && exec_done) |=> (!exec_valid && mem_rd_en)); // R9
endmodule

bind fetch_sequencer fds_checker #(.AW(AW), .OPW(OPW)) u_fds_checker (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd_en(mem_rd_en),
    .exec_valid(exec_valid), .exec_done(exec_done), .ins_class(ins_class),
    .opcode(opcode), .operand(operand), .eff_addr(eff_addr)
);

// File: tb/fetch_sequencer_test.sv
module fetch_sequencer_test;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 5000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] mem_addr;
    logic        mem_rd_en;
    logic [15:0] mem_rdata = '0;
    logic        exec_valid;
    logic        exec_done = 1'b0;
    logic        pc_load = 1'b0;
    logic [11:0] pc_load_val = '0;
    logic [1:0]  ins_class;
    logic [2:0]  opcode;
    logic [11:0] operand;
    logic [11:0] eff_addr;

    logic [15:0] mem [0:4095];

    typedef struct {
        logic [1:0]  cls;
        logic [2:0]  opc;
        logic [11:0] opd;
        logic [11:0] eff;
        int          gap;
        int          reads;
        int          wait_cyc;
        bit          do_load;
        logic [11:0] load_val;
        string       req;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fail = 0;
    bit   started = 1'b0;
    bit   all_done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) if (mem_rd_en) mem_rdata <= mem[mem_addr];

    fetch_sequencer uut (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd_en(mem_rd_en),
        .mem_rdata(mem_rdata), .exec_valid(exec_valid), .exec_done(exec_done),
        .pc_load(pc_load), .pc_load_val(pc_load_val), .ins_class(ins_class),
        .opcode(opcode), .operand(operand), .eff_addr(eff_addr)
    );

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // driver: place an instruction word and queue the result it must produce
    task automatic drive(input logic [11:0] at, input logic [15:0] word,
                         input logic [15:0] ptr_word, input int wait_cyc,
                         input bit do_load, input logic [11:0] load_val, input string req);
        exp_t e;
        bit   sys;
        mem[at] = word;
        sys     = (word[14:12] == 3'b111);
        e.opc   = word[14:12];
        e.opd   = word[11:0];
        e.cls   = !sys ? 2'd0 : (word[15] ? 2'd2 : 2'd1);
        if (!sys && word[15]) begin
            mem[word[11:0]] = ptr_word;
            e.eff   = ptr_word[11:0];
            e.gap   = 5;
            e.reads = 2;
        end else begin
            e.eff   = word[11:0];
            e.gap   = 4;
            e.reads = 1;
        end
        e.wait_cyc = wait_cyc;
        e.do_load  = do_load;
        e.load_val = load_val;
        e.req      = req;
        q.push_back(e);
    endtask

    // monitor: pops the queue at each handoff and compares
    initial begin
        int  cyc = 0;
        int  last = 0;
        int  reads = 0;
        bit  first = 1'b1;
        exp_t e;
        wait (started);
        while (!all_done) begin
            @(negedge clk);
            cyc++;
            if (mem_rd_en) reads++;
            if (exec_valid) begin
                if (q.size() == 0) begin
                    check(1'b0, "R9", "unexpected handoff", 1, 0);
                    all_done = 1'b1;
                end else begin
                    e = q.pop_front();
                    check(ins_class == e.cls, e.req, "ins_class (R5/R6)", ins_class, e.cls);
                    check(opcode == e.opc, "R4", "opcode", opcode, e.opc);
                    check(operand == e.opd, "R4", "operand", operand, e.opd);
                    check(eff_addr == e.eff, e.req, "eff_addr (R7/R8)", eff_addr, e.eff);
                    if (!first) begin
                        check(cyc - last == e.gap, "R9", "handoff latency", cyc - last, e.gap);
                        check(reads == e.reads, "R2", "reads per instruction (R6/R8)", reads, e.reads);
                    end
                    first = 1'b0;
                    for (int w = 0; w < e.wait_cyc; w++) begin
                        pc_load     = 1'b1;   // R11: must be ignored without done
                        pc_load_val = 12'h555;
                        exec_done   = 1'b0;
                        @(negedge clk);
                        cyc++;
                        check(exec_valid && eff_addr == e.eff && operand == e.opd,
                              "R10", "hold while waiting", eff_addr, e.eff);
                    end
                    pc_load     = e.do_load;
                    pc_load_val = e.load_val;
                    exec_done   = 1'b1;
                    last  = cyc;
                    reads = 0;
                    @(negedge clk);
                    cyc++;
                    exec_done = 1'b0;
                    pc_load   = 1'b0;
                    check(!exec_valid, "R9", "valid drops after done", exec_valid, 0);
                    if (mem_rd_en) reads++;
                    if (q.size() == 0) all_done = 1'b1;
                end
            end
        end
    end

    initial begin
        int cycles = 0;
        for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
        drive(12'h000, 16'h1234, 16'h0, 0, 0, 12'h0,   "R7");
        drive(12'h001, 16'hA050, 16'hF7AB, 2, 0, 12'h0, "R8");  // waits with stray pc_load
        drive(12'h002, 16'h7800, 16'h0, 0, 0, 12'h0,   "R6");  // R11 ignored load shows here
        drive(12'h003, 16'hF400, 16'h0, 0, 0, 12'h0,   "R6");
        drive(12'h004, 16'hE123, 16'h0FFF, 0, 0, 12'h0, "R8");
        drive(12'h005, 16'h0000, 16'h0, 0, 1, 12'hFFE, "R7");  // branch to 0xFFE
        drive(12'hFFE, 16'h6ABC, 16'h0, 0, 0, 12'h0,   "R11");
        drive(12'hFFF, 16'h8FFF, 16'h8FFF, 0, 0, 12'h0, "R8");
        drive(12'h000, 16'h1234, 16'h0, 1, 0, 12'h0,   "R3");  // wrapped fetch

        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!exec_valid, "R1", "valid in reset", exec_valid, 0);
        check(mem_rd_en == 1'b1, "R1", "fetch request in reset", mem_rd_en, 1);
        check(mem_addr == 12'h000, "R1", "fetch address in reset", mem_addr, 0);
        rst     = 1'b0;
        started = 1'b1;

        while (!all_done && cycles < MAX_CYCLES) begin
            @(negedge clk);
            cycles++;
        end
        if (!all_done) check(1'b0, "R9", "watchdog expired", cycles, MAX_CYCLES);
        check(q.size() == 0, "R2", "items left unconsumed", q.size(), 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule